// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial input into bytes. It samples the line on a 16x oversampling enable. Characters have 5 to 8 data bits, least significant bit first, an optional parity bit and one stop bit. Each finished character goes into a receive queue together with three error tags: parity, framing and break. The tags stay with the character. The status outputs show a tag only once its character is at the head of the queue.

The host pulls bytes from the head with a pop strobe and samples the status outputs with a status-read strobe. The read strobe clears the head error flags and the overrun flag. A summary flag reports that some errored character is still queued. It is cleared by a read only after every errored character has left the queue.

The receiver recovers in two special cases. After a bad stop bit, it takes that low level as the next start bit and carries straight on with the next character. After a break, it queues one zero character and then waits for the line to go high before it looks for a new start bit. With queue mode off, the queue shrinks to a single holding slot and the summary flag stays low.

Top module: `rxq_receiver`

## Requirements
- R1: A low level seen while idle is accepted as a start bit only if the line is still low at the eighth oversampling tick (tick count 7 from 0). Otherwise the receiver returns to idle and no character is queued.
- R2: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, one per 16 ticks. The byte appears on `rd_data` zero-extended.
- R3: With `cfg_par_en` high, a parity bit follows the data. With `cfg_par_even` high the data bits plus the parity bit must hold an even number of ones; with it low, an odd number. A mismatch sets the character's parity tag.
- R4: A stop-bit sample that reads low, on a character that is not a break, sets the character's framing tag.
- R5: After a framing error the receiver takes the low stop level as the next start bit. It confirms that start bit with one more sample, one tick later, and then receives the following character with no new falling edge.
- R6: When the start, data, parity and stop samples are all low, exactly one entry is queued: data 0, break tag set, framing and parity tags clear. No further character is accepted until the line goes high and a new valid start bit arrives.
- R7: `st_parity`, `st_framing` and `st_break` are set at the same clock edge at which a character carrying the matching tag becomes the queue head, whether by a push into an empty queue or by a pop. A tag on a character that is not at the head has no effect on them.
- R8: A `stat_rd` pulse clears `st_parity`, `st_framing`, `st_break` and `st_overrun` at the next edge.
- R9: In queue mode `st_err_sum` is high while any queued character carries a tag. Once set, it stays high until a `stat_rd` arrives at a time when no tagged character remains.
- R10: With `cfg_fifo_en` low the queue holds one character and `st_err_sum` reads 0.
- R11: The queue holds 16 characters. A character that completes while the queue is full is dropped and sets `st_overrun`; the queued contents are unchanged.
- R12: `rd_ready` is high exactly when the queue is non-empty. `rd_data` shows the head byte. A `rd_pop` pulse removes the head at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial input, already synchronised, idle high |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character data |
| rd_ready | output | 1 | Queue non-empty |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| st_parity | output | 1 | Parity error on a character that reached the head |
| st_framing | output | 1 | Framing error on a character that reached the head |
| st_break | output | 1 | Break on a character that reached the head |
| st_overrun | output | 1 | A character was dropped because the queue was full |
| st_err_sum | output | 1 | Summary: a tagged character is or was queued and no clearing read has followed |

## Verification
A character is written to the queue at the edge that takes the stop-bit sample. That edge falls 7 + 16 × (bits after start) ticks after the start edge was first seen. The bench therefore checks only after the whole stop-bit period plus some idle cycles, when the entry is settled. Pops and status reads act at the next rising edge, so the bench raises each strobe on a falling edge and checks the flags on the following falling edge. This pins down the exact edge at which a head tag appears (R7) or a flag clears (R8, R9). The resynchronisation case keeps to the bit grid: the bad stop slot is driven as the next start bit, so each later data sample lands near the middle of its bit.

// File: rtl/rxq_pkg.sv
// Shared constants and types for the tagged serial receiver.
// Assumes data characters are at most RXQ_DW bits wide.
package rxq_pkg;

    localparam int RXQ_DW       = 8;   // widest data character
    localparam int RXQ_MIN_BITS = 5;   // length code 0 selects this many bits
    localparam int RXQ_NERR     = 3;   // per-character error tags

    // positions of the error tags inside an entry
    localparam int ERR_PAR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_BRK = 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef struct packed {
        logic [RXQ_DW-1:0]   data;
        logic [RXQ_NERR-1:0] err;
    } rxq_entry_t;

endpackage

// File: rtl/rxq_sampler.sv
// Oversampling receive state machine.
// Finds start bits, samples each bit near its middle, checks parity and
// stop, spots breaks and resynchronises after a framing error. It emits
// a one-cycle push with a tagged entry at the stop-bit sample.
// Assumes rx is already synchronised to clk and tick pulses OSR times per bit.
module rxq_sampler
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       push,
    output rxq_entry_t push_entry
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(RXQ_DW);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [IDX_W:0]   DW_VAL   = (IDX_W + 1)'(RXQ_DW);
    localparam logic [IDX_W:0]   MIN_VAL  = (IDX_W + 1)'(RXQ_MIN_BITS);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [RXQ_DW-1:0] shreg;
    logic              par_bit;

    logic [IDX_W:0]    nbits;
    logic [IDX_W:0]    last_idx;
    logic [RXQ_DW-1:0] aligned;
    logic              par_bad;
    logic              is_brk;
    logic              stop_tick;

    // Decode the character length and move the shifted bits down to bit 0.
    always_comb begin
        nbits    = MIN_VAL + {{(IDX_W - 1){1'b0}}, cfg_len};
        last_idx = nbits - 1'b1;
        aligned  = shreg >> (DW_VAL - nbits);
    end

    // Judge the completed frame at the stop-bit sample.
    always_comb begin
        stop_tick = tick && (state == RX_STOP) && (cnt == LAST_CNT);
        par_bad   = (^aligned ^ par_bit) ^ ~cfg_par_even;
        is_brk    = !rx && (aligned == '0) && (!cfg_par_en || !par_bit);
    end

    // Build the entry pushed into the queue.
    always_comb begin
        push                     = stop_tick;
        push_entry.data          = is_brk ? '0 : aligned;
        push_entry.err[ERR_PAR]  = !is_brk && cfg_par_en && par_bad;
        push_entry.err[ERR_FRM]  = !is_brk && !rx;
        push_entry.err[ERR_BRK]  = is_brk;
    end

    // Receive sequencer: advances once per oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            case (state)
                RX_IDLE: begin
                    if (!rx) begin
                        state <= RX_START;
                        cnt   <= CNT_W'(1);
                    end
                end
                RX_START: begin
                    if (cnt == MID_CNT) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                        state   <= rx ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST_CNT) begin
                        cnt   <= '0;
                        shreg <= {rx, shreg[RXQ_DW-1:1]};
                        if ({1'b0, bit_idx} == last_idx) begin
                            state <= cfg_par_en ? RX_PARITY : RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (cnt == LAST_CNT) begin
                        cnt     <= '0;
                        par_bit <= rx;
                        state   <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == LAST_CNT) begin
                        if (rx) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end else if (is_brk) begin
                            cnt   <= '0;
                            state <= RX_BREAK;
                        end else begin
                            // low stop taken as the next start, one more sample due
                            cnt   <= MID_CNT;
                            state <= RX_START;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BREAK: begin
                    if (rx) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxq_fifo.sv
// Receive queue of tagged entries.
// Holds DEPTH entries in queue mode, or one entry when queue mode is off.
// Counts tagged entries and reports the tags of a character at the moment
// it becomes the head. Assumes DEPTH is a power of two and that queue
// mode changes only while the queue is empty.
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fifo_en,
    input  logic                     push,
    input  rxq_entry_t               push_entry,
    input  logic                     pop,
    output rxq_entry_t               head,
    output logic                     empty,
    output logic                     overrun,
    output logic                     head_load,
    output logic [RXQ_NERR-1:0]      head_err,
    output logic                     err_left_nxt,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] err_cnt_nxt;
    logic [CNT_W-1:0] cap;
    logic             full;
    logic             push_ok;
    logic             pop_ok;
    logic             push_tag;
    logic             pop_tag;
    rxq_entry_t       next_head;

    // Capacity, accept and drop decisions.
    always_comb begin
        cap       = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full      = (count >= cap);
        empty     = (count == '0);
        push_ok   = push && !full;
        overrun   = push && full;
        pop_ok    = pop && !empty;
        head      = mem[rd_ptr];
        next_head = mem[rd_ptr + PTR_W'(1)];
        push_tag  = push_ok && (|push_entry.err);
        pop_tag   = pop_ok && (|head.err);
    end

    // Find which character becomes the head at this edge, and its tags.
    always_comb begin
        head_load = (push_ok && empty)
                 || (pop_ok && (count > CNT_W'(1)))
                 || (pop_ok && (count == CNT_W'(1)) && push_ok);
        head_err  = (pop_ok && (count > CNT_W'(1))) ? next_head.err : push_entry.err;
    end

    // Next number of tagged entries in the queue.
    always_comb begin
        err_cnt_nxt = err_cnt;
        case ({push_tag, pop_tag})
            2'b10:   err_cnt_nxt = err_cnt + 1'b1;
            2'b01:   err_cnt_nxt = err_cnt - 1'b1;
            default: err_cnt_nxt = err_cnt;
        endcase
        err_left_nxt = (err_cnt_nxt != '0);
    end

    // Entry storage: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    // Pointer, occupancy and tag-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            err_cnt <= err_cnt_nxt;
        end
    end

endmodule

// File: rtl/rxq_status.sv
// Sticky status flags.
// Head tags latch when their character becomes the head. Overrun latches
// on a dropped character. A status read clears them. The summary flag
// follows the queued tag count and is released only by a read.
module rxq_status
    import rxq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_en,
    input  logic                stat_rd,
    input  logic                head_load,
    input  logic [RXQ_NERR-1:0] head_err,
    input  logic                overrun,
    input  logic                err_left_nxt,
    output logic [RXQ_NERR-1:0] flags,
    output logic                ovr_flag,
    output logic                sum_flag
);

    // One sticky flag per error tag kind.
    for (genvar g = 0; g < RXQ_NERR; g++) begin : g_tag
        // Set from the new head's tag, clear on a status read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else begin
                flags[g] <= (flags[g] && !stat_rd) || (head_load && head_err[g]);
            end
        end
    end

    // Overrun flag: set on a dropped character, cleared on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else begin
            ovr_flag <= (ovr_flag && !stat_rd) || overrun;
        end
    end

    // Summary flag: follows queued tags, held until a read finds none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_flag <= 1'b0;
        end else begin
            sum_flag <= fifo_en && (err_left_nxt || (sum_flag && !stat_rd));
        end
    end

endmodule

// File: rtl/rxq_receiver.sv
// Top of the tagged serial receiver: sampler, tagged queue and status flags.
// Assumes rx_in is synchronised and tick16 gives 16 enables per bit time.
module rxq_receiver
    import rxq_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_fifo_en,
    input  logic              rd_pop,
    output logic [RXQ_DW-1:0] rd_data,
    output logic              rd_ready,
    input  logic              stat_rd,
    output logic              st_parity,
    output logic              st_framing,
    output logic              st_break,
    output logic              st_overrun,
    output logic              st_err_sum
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                push;
    rxq_entry_t          push_entry;
    rxq_entry_t          head;
    logic                empty;
    logic                overrun;
    logic                head_load;
    logic [RXQ_NERR-1:0] head_err;
    logic                err_left_nxt;
    logic [CNT_W-1:0]    fifo_cnt;
    logic [RXQ_NERR-1:0] flags;

    rxq_sampler #(
        .OSR (OSR)
    ) u_sampler (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .rx           (rx_in),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .push         (push),
        .push_entry   (push_entry)
    );

    rxq_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (cfg_fifo_en),
        .push         (push),
        .push_entry   (push_entry),
        .pop          (rd_pop),
        .head         (head),
        .empty        (empty),
        .overrun      (overrun),
        .head_load    (head_load),
        .head_err     (head_err),
        .err_left_nxt (err_left_nxt),
        .count        (fifo_cnt)
    );

    rxq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (cfg_fifo_en),
        .stat_rd      (stat_rd),
        .head_load    (head_load),
        .head_err     (head_err),
        .overrun      (overrun),
        .err_left_nxt (err_left_nxt),
        .flags        (flags),
        .ovr_flag     (st_overrun),
        .sum_flag     (st_err_sum)
    );

    // Present the head byte and the flag outputs.
    always_comb begin
        rd_ready   = !empty;
        rd_data    = empty ? '0 : head.data;
        st_parity  = flags[ERR_PAR];
        st_framing = flags[ERR_FRM];
        st_break   = flags[ERR_BRK];
    end

endmodule

// File: rtl/rxq_receiver_chk.sv
// Property checker for rxq_receiver, attached by bind.
module rxq_receiver_chk
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_fifo_en,
    input logic                       rd_pop,
    input logic                       rd_ready,
    input logic                       stat_rd,
    input logic                       st_parity,
    input logic                       st_framing,
    input logic                       st_break,
    input logic                       st_overrun,
    input logic                       st_err_sum,
    input logic                       push,
    input rxq_entry_t                 push_entry,
    input logic                       overrun,
    input logic                       head_load,
    input logic [RXQ_NERR-1:0]        head_err,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R11

    AST_ONE_SLOT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |-> fifo_cnt <= ($clog2(DEPTH+1))'(1)); // R10

    AST_SUM_ZERO_NONQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |=> !st_err_sum); // R10

    AST_BREAK_ZERO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_entry.err[ERR_BRK] |-> push_entry.data == '0 && !push_entry.err[ERR_FRM]); // R6

    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> st_overrun); // R11

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !head_load |=> !st_parity && !st_framing && !st_break && !st_overrun); // R8

    AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push && !rd_pop |=> rd_ready); // R12

    AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_err_sum && !stat_rd && cfg_fifo_en |=> st_err_sum); // R9

    AST_HEAD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        head_load && head_err[ERR_PAR] |=> st_parity); // R7

endmodule

bind rxq_receiver rxq_receiver_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fifo_en (cfg_fifo_en),
    .rd_pop      (rd_pop),
    .rd_ready    (rd_ready),
    .stat_rd     (stat_rd),
    .st_parity   (st_parity),
    .st_framing  (st_framing),
    .st_break    (st_break),
    .st_overrun  (st_overrun),
    .st_err_sum  (st_err_sum),
    .push        (push),
    .push_entry  (push_entry),
    .overrun     (overrun),
    .head_load   (head_load),
    .head_err    (head_err),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/rxq_receiver_tb.sv
// Directed bench for rxq_receiver: one task per scenario, each checking itself.
module rxq_receiver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;
    localparam int WDOG_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b1;
    logic       cfg_fifo_en = 1'b1;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ready;
    logic       stat_rd = 1'b0;
    logic       st_parity;
    logic       st_framing;
    logic       st_break;
    logic       st_overrun;
    logic       st_err_sum;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxq_receiver u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .rx_in        (rx_in),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_fifo_en  (cfg_fifo_en),
        .rd_pop       (rd_pop),
        .rd_data      (rd_data),
        .rd_ready     (rd_ready),
        .stat_rd      (stat_rd),
        .st_parity    (st_parity),
        .st_framing   (st_framing),
        .st_break     (st_break),
        .st_overrun   (st_overrun),
        .st_err_sum   (st_err_sum)
    );

    task automatic chk1(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic logic par_calc(input logic [7:0] d, input int nb, input logic even);
        logic p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        return even ? p : ~p;
    endfunction

    task automatic drive_bit(input logic b);
        rx_in = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_body(input logic [7:0] d, input int nb, input logic pon,
                             input logic pbit, input logic stopv);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (pon) drive_bit(pbit);
        drive_bit(stopv);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic pon,
                              input logic pbit, input logic stopv);
        drive_bit(1'b0);
        send_body(d, nb, pon, pbit, stopv);
    endtask

    task automatic idle(input int n);
        rx_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // R12 and R8: state right after reset.
    task automatic t_reset();
        chk1(rd_ready, 1'b0, "R12", "ready after reset");
        chk1(st_parity | st_framing | st_break | st_overrun, 1'b0, "R8", "flags after reset");
        chk1(st_err_sum, 1'b0, "R9", "summary after reset");
    endtask

    // R2 and R12: a plain 8-bit character.
    task automatic t_basic();
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        idle(16);
        chk1(rd_ready, 1'b1, "R12", "ready after char");
        chk8(rd_data, 8'hA5, "R2", "8-bit data");
        chk1(st_parity | st_framing | st_break, 1'b0, "R4", "clean char flags");
        pop_one();
        chk1(rd_ready, 1'b0, "R12", "ready after pop");
    endtask

    // R2 and R3: 5-bit and 7-bit lengths, odd parity accepted.
    task automatic t_lengths();
        cfg_len = 2'd0;
        send_frame(8'h15, 5, 1'b0, 1'b0, 1'b1);
        idle(16);
        chk8(rd_data, 8'h15, "R2", "5-bit data");
        pop_one();
        cfg_len = 2'd2;
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b0;
        send_frame(8'h5B, 7, 1'b1, par_calc(8'h5B, 7, 1'b0), 1'b1);
        idle(16);
        chk8(rd_data, 8'h5B, "R2", "7-bit data");
        chk1(st_parity, 1'b0, "R3", "odd parity correct");
        pop_one();
        cfg_len = 2'd3;
        cfg_par_en = 1'b0;
        cfg_par_even = 1'b1;
    endtask

    // R3, R8, R9: bad even parity, read clears flag, summary held.
    task automatic t_parity();
        cfg_par_en = 1'b1;
        send_frame(8'h3C, 8, 1'b1, ~par_calc(8'h3C, 8, 1'b1), 1'b1);
        idle(20);
        chk8(rd_data, 8'h3C, "R3", "data with bad parity");
        chk1(st_parity, 1'b1, "R3", "parity flag");
        chk1(st_err_sum, 1'b1, "R9", "summary set");
        read_status();
        chk1(st_parity, 1'b0, "R8", "parity cleared by read");
        chk1(st_err_sum, 1'b1, "R9", "summary kept while tagged char queued");
        pop_one();
        chk1(st_err_sum, 1'b1, "R9", "summary kept after pop until read");
        read_status();
        chk1(st_err_sum, 1'b0, "R9", "summary cleared by read");
        cfg_par_en = 1'b0;
    endtask

    // R1: a short low pulse is not a start bit.
    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        idle(200);
        chk1(rd_ready, 1'b0, "R1", "no char from glitch");
    endtask

    // R4, R5, R7: bad stop followed at once by the next character.
    task automatic t_resync();
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0);
        send_body(8'h81, 8, 1'b0, 1'b0, 1'b1);
        idle(20);
        chk8(rd_data, 8'h55, "R4", "first char data");
        chk1(st_framing, 1'b1, "R4", "framing flag");
        read_status();
        chk1(st_framing, 1'b0, "R8", "framing cleared");
        pop_one();
        chk1(rd_ready, 1'b1, "R5", "resynced char present");
        chk8(rd_data, 8'h81, "R5", "resynced char data");
        chk1(st_framing, 1'b0, "R7", "clean head sets no flag");
        read_status();
        pop_one();
        chk1(rd_ready, 1'b0, "R5", "exactly two chars");
    endtask

    // R7, R9: tags shown only when their char is the head.
    task automatic t_head_tags();
        cfg_par_en = 1'b1;
        send_frame(8'h11, 8, 1'b1, par_calc(8'h11, 8, 1'b1), 1'b1);
        idle(4);
        send_frame(8'h22, 8, 1'b1, ~par_calc(8'h22, 8, 1'b1), 1'b1);
        idle(4);
        send_frame(8'h33, 8, 1'b1, par_calc(8'h33, 8, 1'b1), 1'b1);
        idle(20);
        chk8(rd_data, 8'h11, "R7", "head is first char");
        chk1(st_parity, 1'b0, "R7", "tag behind head hidden");
        chk1(st_err_sum, 1'b1, "R9", "summary sees queued tag");
        pop_one();
        chk8(rd_data, 8'h22, "R7", "errored char at head");
        chk1(st_parity, 1'b1, "R7", "tag shown at head edge");
        pop_one();
        chk1(st_parity, 1'b1, "R7", "flag sticky past head");
        chk1(st_err_sum, 1'b1, "R9", "summary held after pop");
        read_status();
        chk1(st_parity, 1'b0, "R8", "read clears parity");
        chk1(st_err_sum, 1'b0, "R9", "summary cleared, none left");
        pop_one();
        chk1(rd_ready, 1'b0, "R12", "queue drained");
        cfg_par_en = 1'b0;
    endtask

    // R6: long low gives one zero char with break tag.
    task automatic t_break();
        rx_in = 1'b0;
        repeat (400) @(negedge clk);
        idle(40);
        chk1(rd_ready, 1'b1, "R6", "break entry present");
        chk8(rd_data, 8'h00, "R6", "break data zero");
        chk1(st_break, 1'b1, "R6", "break flag");
        chk1(st_framing, 1'b0, "R6", "no framing on break");
        pop_one();
        chk1(rd_ready, 1'b0, "R6", "only one break entry");
        read_status();
        chk1(st_break, 1'b0, "R8", "break cleared");
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1);
        idle(16);
        chk8(rd_data, 8'h5A, "R6", "char after break");
        pop_one();
    endtask

    // R10, R11: one-slot mode, summary zero, overrun keeps held char.
    task automatic t_one_slot();
        cfg_fifo_en = 1'b0;
        cfg_par_en = 1'b1;
        send_frame(8'h3C, 8, 1'b1, ~par_calc(8'h3C, 8, 1'b1), 1'b1);
        idle(16);
        chk1(st_parity, 1'b1, "R10", "parity flag in one-slot mode");
        chk1(st_err_sum, 1'b0, "R10", "summary zero in one-slot mode");
        send_frame(8'h44, 8, 1'b1, par_calc(8'h44, 8, 1'b1), 1'b1);
        idle(16);
        chk1(st_overrun, 1'b1, "R10", "second char overruns slot");
        chk8(rd_data, 8'h3C, "R11", "held char kept");
        read_status();
        chk1(st_overrun, 1'b0, "R8", "overrun cleared");
        pop_one();
        chk1(rd_ready, 1'b0, "R10", "slot empty");
        cfg_par_en = 1'b0;
        cfg_fifo_en = 1'b1;
        @(negedge clk);
    endtask

    // R11: 17 chars into a 16-deep queue.
    task automatic t_overrun();
        for (int i = 0; i < 17; i++) begin
            send_frame(8'(8'h40 + i), 8, 1'b0, 1'b0, 1'b1);
            idle(4);
        end
        idle(16);
        chk1(st_overrun, 1'b1, "R11", "overrun flag");
        for (int i = 0; i < 16; i++) begin
            chk8(rd_data, 8'(8'h40 + i), "R11", "queued order");
            pop_one();
        end
        chk1(rd_ready, 1'b0, "R11", "17th char dropped");
        read_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_glitch();
        t_resync();
        t_head_tags();
        t_break();
        t_one_slot();
        t_overrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule